// File: doc/BRIEF.md
# Four-Mode GPIO Port with Masked Output and Per-Pin Alias Window

This block is one general-purpose I/O port of up to sixteen pins, controlled over a plain 32-bit register bus. Each pin carries a drive mode (input, push-pull, open-drain or quasi-bidirectional), a bit of the output data register, a write-protect bit that shields that output bit from whole-register writes, an input-path disable bit, a pull-select code and a slew-select bit. The block turns these into pad-side output-enable, output-value and weak-pull-request signals, and samples the pad inputs through a synchronizer into a readable level register.

Beside the register window there is an alias window in which every pin owns one word. A read of that word returns the pin's sampled input level in bit 0, and a write sets the pin's output bit from bit 0 of the write data, without regard to the write-protect mask. A parameter lists which pins exist; absent pins read 0 everywhere and never drive their pads. The bus has a request, a write strobe, a byte address, write data and combinational read data.

Top module: `gpio_port_regs`

## Requirements
- R1: The mode field of pin n is bits [2n+1:2n] of the register at offset 0x00; code 0 leaves the pad undriven, code 1 drives it continuously, and the pad output value is always the pin's output data bit.
- R2: Pins whose bit in the implemented-pin parameter is 0 read as 0 in every register and in their alias word, ignore writes, and never assert output-enable or weak-pull request.
- R3: The mask register (offset 0x08, bit n for pin n) protects output bits: a write to the output data register (offset 0x04, bits [15:0]) leaves every pin whose mask bit is 1 unchanged.
- R4: Setting bit 16+n of the input-disable register (offset 0x0C) forces pin n's sampled level to read 0; bits [15:0] of that register read 0.
- R5: The alias word of pin n sits at byte address ALIAS_BASE + 0x40*PORT_IDX + 4*n; reading it returns pin n's sampled level in bit 0 and zeros above.
- R6: Writing a pin's alias word sets that pin's output bit to bit 0 of the write data; other data bits, and alias words of other port indexes, have no effect.
- R7: Alias writes change the output bit even when the pin's mask bit is 1.
- R8: In mode code 2 (open-drain) output-enable is asserted only while the output bit is 0.
- R9: In mode code 3 (quasi-bidirectional) output-enable is asserted while the output bit is 0 and for exactly one cycle after the output bit rises from 0 to 1; otherwise, with the output bit at 1, only the weak-pull request is asserted.
- R10: The pull code of pin n (register at offset 0x14, bits [2n+1:2n]: 0 none, 1 up, 2 down) and the slew bit (offset 0x18, bit n: 0 normal, 1 high) appear on the pad pull and slew outputs and read back.
- R11: A change on a pad input appears in the level register (offset 0x10, bit n) after the third rising clock edge.
- R12: After reset all pins are inputs, the output data register holds 1 on every implemented pin, and the mask, input-disable, pull and slew registers are all 0; reset acts at once and is released two edges after the reset input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request |
| pad_in | input | 16 | Pad input levels, asynchronous |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output value |
| pad_weak_pu | output | 16 | Per-pin weak pull-up request (quasi-bidirectional) |
| pad_pull | output | 32 | Per-pin 2-bit pull-select code |
| pad_slew | output | 16 | Per-pin slew-select bit |

## Verification
Read data is combinational, so each read is sampled a short delay after the bench sets the request, within the same cycle; register writes land on the next rising edge and are observed at the following falling edge, both on reads and on the pad outputs. The quasi-bidirectional strong-high pulse is checked at the first falling edge after the write that raised the bit and found gone at the next one. Pad input changes are read back after one, two and three edges, expecting the old level twice and the new level on the third, while a behavioural reference model compares every pad output at every falling edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned MAX_PINS = 16;

  typedef enum logic [1:0] {
    PM_IN    = 2'd0,
    PM_PUSH  = 2'd1,
    PM_DRAIN = 2'd2,
    PM_QUASI = 2'd3
  } pin_mode_e;

  // word index (byte address bits [5:2]) inside the register window
  localparam logic [3:0] WIX_MODE  = 4'd0;
  localparam logic [3:0] WIX_DOUT  = 4'd1;
  localparam logic [3:0] WIX_WMASK = 4'd2;
  localparam logic [3:0] WIX_INOFF = 4'd3;
  localparam logic [3:0] WIX_LEVEL = 4'd4;
  localparam logic [3:0] WIX_PULL  = 4'd5;
  localparam logic [3:0] WIX_SLEW  = 4'd6;

  // spread a per-pin mask over 2-bit fields
  function automatic logic [2*MAX_PINS-1:0] widen2(input logic [MAX_PINS-1:0] m);
    logic [2*MAX_PINS-1:0] r;
    for (int i = 0; i < MAX_PINS; i++) r[2*i +: 2] = {2{m[i]}};
    return r;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_n_o = ff2_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_port_pkg::*;
#(
  parameter logic [MAX_PINS-1:0] PIN_MASK = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_PINS-1:0] pad_i,
  input  logic [MAX_PINS-1:0] off_i,
  output logic [MAX_PINS-1:0] level_o
);
  logic [MAX_PINS-1:0] meta_q, stab_q, lvl_q, lvl_d;

  always_comb begin
    lvl_d = stab_q & ~off_i & PIN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= pad_i;
      stab_q <= meta_q;
      lvl_q  <= lvl_d;
    end
  end

  assign level_o = lvl_q;

  // a disabled input path must read 0 on the cycle after the disable is seen
  assert_off_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((level_o & $past(off_i)) == '0));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter logic [MAX_PINS-1:0] PIN_MASK = '1
) (
  input  logic [2*MAX_PINS-1:0] mode_i,
  input  logic [MAX_PINS-1:0]   dout_i,
  input  logic [MAX_PINS-1:0]   boost_i,
  output logic [MAX_PINS-1:0]   oe_o,
  output logic [MAX_PINS-1:0]   out_o,
  output logic [MAX_PINS-1:0]   weak_o
);
  for (genvar gi = 0; gi < MAX_PINS; gi++) begin : g_pin
    if (PIN_MASK[gi]) begin : g_live
      logic [1:0] m;
      assign m = mode_i[2*gi +: 2];
      assign oe_o[gi]   = (m == PM_PUSH)
                        | ((m == PM_DRAIN) & ~dout_i[gi])
                        | ((m == PM_QUASI) & (~dout_i[gi] | boost_i[gi]));
      assign weak_o[gi] = (m == PM_QUASI) & dout_i[gi] & ~boost_i[gi];
      assign out_o[gi]  = dout_i[gi];
    end else begin : g_dead
      assign oe_o[gi]   = 1'b0;
      assign weak_o[gi] = 1'b0;
      assign out_o[gi]  = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter logic [MAX_PINS-1:0] PIN_MASK   = 16'hFFFF,
  parameter int unsigned         ADDR_W     = 12,
  parameter int unsigned         ALIAS_BASE = 'h800,
  parameter int unsigned         PORT_IDX   = 0
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [MAX_PINS-1:0]   pad_in,
  output logic [MAX_PINS-1:0]   pad_oe,
  output logic [MAX_PINS-1:0]   pad_out,
  output logic [MAX_PINS-1:0]   pad_weak_pu,
  output logic [2*MAX_PINS-1:0] pad_pull,
  output logic [MAX_PINS-1:0]   pad_slew
);
  localparam logic [2*MAX_PINS-1:0] PAIR_MASK  = widen2(PIN_MASK);
  localparam logic [ADDR_W-7:0]     ALIAS_PAGE = (ADDR_W-6)'((ALIAS_BASE + PORT_IDX*64) >> 6);

  logic rst_n_s;

  gpio_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  // ---------------- address decode ----------------
  logic       aligned, reg_hit, alias_hit;
  logic       reg_wr, reg_rd, alias_wr, alias_rd;
  logic [3:0] word_ix, alias_pin;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign word_ix   = bus_addr[5:2];
  assign alias_pin = bus_addr[5:2];
  assign reg_hit   = bus_req & aligned & (bus_addr[ADDR_W-1:6] == '0);
  assign alias_hit = bus_req & aligned & (bus_addr[ADDR_W-1:6] == ALIAS_PAGE);
  assign reg_wr    = reg_hit & bus_we;
  assign reg_rd    = reg_hit & ~bus_we;
  assign alias_wr  = alias_hit & bus_we;
  assign alias_rd  = alias_hit & ~bus_we;

  // ---------------- state ----------------
  logic [2*MAX_PINS-1:0] mode_q, mode_d, pull_q, pull_d;
  logic [MAX_PINS-1:0]   dout_q, dout_d, wmask_q, wmask_d;
  logic [MAX_PINS-1:0]   inoff_q, inoff_d, slew_q, slew_d;
  logic [MAX_PINS-1:0]   boost_q, boost_d;
  logic                  mode_en, dout_en, wmask_en, inoff_en, pull_en, slew_en;
  logic [MAX_PINS-1:0]   level;

  // next-state and clock enables
  always_comb begin
    mode_en  = 1'b0;
    dout_en  = 1'b0;
    wmask_en = 1'b0;
    inoff_en = 1'b0;
    pull_en  = 1'b0;
    slew_en  = 1'b0;
    mode_d   = bus_wdata & PAIR_MASK;
    pull_d   = bus_wdata & PAIR_MASK;
    wmask_d  = bus_wdata[MAX_PINS-1:0] & PIN_MASK;
    slew_d   = bus_wdata[MAX_PINS-1:0] & PIN_MASK;
    inoff_d  = bus_wdata[31:16] & PIN_MASK;
    dout_d   = dout_q;
    if (reg_wr) begin
      case (word_ix)
        WIX_MODE:  mode_en  = 1'b1;
        WIX_DOUT: begin
          dout_en = 1'b1;
          dout_d  = ((bus_wdata[MAX_PINS-1:0] & ~wmask_q) | (dout_q & wmask_q)) & PIN_MASK;
        end
        WIX_WMASK: wmask_en = 1'b1;
        WIX_INOFF: inoff_en = 1'b1;
        WIX_PULL:  pull_en  = 1'b1;
        WIX_SLEW:  slew_en  = 1'b1;
        default: ;
      endcase
    end
    if (alias_wr && PIN_MASK[alias_pin]) begin
      dout_en           = 1'b1;
      dout_d[alias_pin] = bus_wdata[0];
    end
    boost_d = dout_d & ~dout_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q  <= '0;
      dout_q  <= PIN_MASK;
      wmask_q <= '0;
      inoff_q <= '0;
      pull_q  <= '0;
      slew_q  <= '0;
      boost_q <= '0;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (dout_en)  dout_q  <= dout_d;
      if (wmask_en) wmask_q <= wmask_d;
      if (inoff_en) inoff_q <= inoff_d;
      if (pull_en)  pull_q  <= pull_d;
      if (slew_en)  slew_q  <= slew_d;
      boost_q <= boost_d;
    end
  end

  // ---------------- input path ----------------
  gpio_in_sync #(.PIN_MASK(PIN_MASK)) u_in (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pad_i   (pad_in),
    .off_i   (inoff_q),
    .level_o (level)
  );

  // ---------------- pad drive ----------------
  gpio_pad_drive #(.PIN_MASK(PIN_MASK)) u_drv (
    .mode_i  (mode_q),
    .dout_i  (dout_q),
    .boost_i (boost_q),
    .oe_o    (pad_oe),
    .out_o   (pad_out),
    .weak_o  (pad_weak_pu)
  );

  assign pad_pull = pull_q;
  assign pad_slew = slew_q;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (reg_rd) begin
      case (word_ix)
        WIX_MODE:  bus_rdata = mode_q;
        WIX_DOUT:  bus_rdata = {16'h0, dout_q};
        WIX_WMASK: bus_rdata = {16'h0, wmask_q};
        WIX_INOFF: bus_rdata = {inoff_q, 16'h0};
        WIX_LEVEL: bus_rdata = {16'h0, level};
        WIX_PULL:  bus_rdata = pull_q;
        WIX_SLEW:  bus_rdata = {16'h0, slew_q};
        default:   bus_rdata = '0;
      endcase
    end else if (alias_rd) begin
      bus_rdata = {31'h0, level[alias_pin]};
    end
  end

  // ---------------- assertions ----------------
  assert_masked_bits_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && word_ix == WIX_DOUT) |=>
      ((dout_q & $past(wmask_q)) == ($past(dout_q) & $past(wmask_q))));

  assert_alias_ignores_mask_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alias_wr && PIN_MASK[alias_pin]) |=> (dout_q[$past(alias_pin)] == $past(bus_wdata[0])));

  assert_boost_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (boost_q != '0) |=> ((boost_q & $past(boost_q)) == '0));

  assert_absent_alias_zero_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alias_rd && !PIN_MASK[alias_pin]) |-> (bus_rdata == '0));

  assert_absent_pads_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |-> (((pad_oe | pad_weak_pu | pad_out) & ~PIN_MASK) == '0));

endmodule

// File: tb/sim_gpio_port_regs.sv
`timescale 1ns/1ps
module sim_gpio_port_regs;
  localparam logic [15:0] PM = 16'h7FFF;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_oe, pad_out, pad_weak_pu, pad_slew;
  logic [31:0] pad_pull;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #10 clk = ~clk;

  gpio_port_regs #(.PIN_MASK(PM), .PORT_IDX(2)) u0 (
    .clk(clk), .arst_n(arst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_weak_pu(pad_weak_pu), .pad_pull(pad_pull), .pad_slew(pad_slew)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mode, m_pull, pm2;
  logic [15:0] m_dout, m_mask, m_off, m_slew, m_boost, m_s1, m_s2, m_lvl;
  int          rel = 0;

  task automatic m_reset();
    m_mode = '0; m_pull = '0; m_dout = PM; m_mask = '0; m_off = '0;
    m_slew = '0; m_boost = '0; m_s1 = '0; m_s2 = '0; m_lvl = '0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pm2[2*i +: 2] = {2{PM[i]}};
    m_reset();
  end

  always @(posedge clk) begin
    logic [15:0] nd, nl;
    if (!arst_n) begin
      rel = 0; m_reset();
    end else if (rel < 2) begin
      rel++; m_reset();
    end else begin
      nd = m_dout;
      nl = m_s2 & ~m_off & PM;
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (bus_req && bus_we && bus_addr[1:0] == 2'b00) begin
        if (bus_addr < 12'h040) begin
          case (bus_addr[5:2])
            4'd0: m_mode = bus_wdata & pm2;
            4'd1: nd = ((bus_wdata[15:0] & ~m_mask) | (m_dout & m_mask)) & PM;
            4'd2: m_mask = bus_wdata[15:0] & PM;
            4'd3: m_off = bus_wdata[31:16] & PM;
            4'd5: m_pull = bus_wdata & pm2;
            4'd6: m_slew = bus_wdata[15:0] & PM;
            default: ;
          endcase
        end else if (bus_addr >= 12'h880 && bus_addr < 12'h8C0) begin
          if (PM[bus_addr[5:2]]) nd[bus_addr[5:2]] = bus_wdata[0];
        end
      end
      m_boost = nd & ~m_dout;
      m_dout  = nd;
      m_lvl   = nl;
    end
  end

  // every falling edge: compare all pad outputs with the model
  always @(negedge clk) begin
    logic [15:0] e_oe, e_out, e_weak;
    e_oe = '0; e_out = '0; e_weak = '0;
    for (int i = 0; i < 16; i++) begin
      if (PM[i]) begin
        e_out[i] = m_dout[i];
        case (m_mode[2*i +: 2])
          2'd1: e_oe[i] = 1'b1;
          2'd2: e_oe[i] = ~m_dout[i];
          2'd3: begin
            e_oe[i]   = ~m_dout[i] | m_boost[i];
            e_weak[i] = m_dout[i] & ~m_boost[i];
          end
          default: ;
        endcase
      end
    end
    n_checks++;
    if (pad_oe !== e_oe || pad_out !== e_out || pad_weak_pu !== e_weak ||
        pad_pull !== m_pull || pad_slew !== m_slew) begin
      n_fail++;
      $display("FAIL R1/R8/R9/R10/R12 pads at %0t: oe %h out %h weak %h pull %h slew %h expected %h %h %h %h %h",
               $time, pad_oe, pad_out, pad_weak_pu, pad_pull, pad_slew,
               e_oe, e_out, e_weak, m_pull, m_slew);
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    check(tag, bus_rdata, exp);
    bus_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    rd("R12 mode reset", 12'h000, 32'h0);
    rd("R12 dout reset, R2 absent pin", 12'h004, 32'h0000_7FFF);
    rd("R12 mask reset", 12'h008, 32'h0);
    rd("R12 input-disable reset", 12'h00C, 32'h0);
    check("R12 no pad driven", {16'h0, pad_oe}, 32'h0);

    // R1 mode codes, absent pin 15 ignored (R2)
    wr(12'h000, 32'h4000_0039);
    #1;
    check("R1/R8 oe with output bits high", {16'h0, pad_oe}, 32'h0001);
    check("R9 weak pull when quasi high", {16'h0, pad_weak_pu}, 32'h0004);
    rd("R2 mode readback masked", 12'h000, 32'h0000_0039);

    // R8 open-drain and quasi drive low
    wr(12'h004, 32'h0);
    #1;
    check("R8/R9 all drive low", {16'h0, pad_oe}, 32'h0007);
    check("R1 pad value", {16'h0, pad_out}, 32'h0);

    // R9 quasi rise: strong for one cycle then weak
    wr(12'h004, 32'h0000_0004);
    #1;
    check("R9 boost cycle oe", {16'h0, pad_oe}, 32'h0007);
    check("R9 boost cycle weak", {16'h0, pad_weak_pu}, 32'h0);
    @(negedge clk); #1;
    check("R9 after boost oe", {16'h0, pad_oe}, 32'h0003);
    check("R9 after boost weak", {16'h0, pad_weak_pu}, 32'h0004);

    // R3 mask
    wr(12'h008, 32'h0000_00FF);
    rd("R3 mask readback", 12'h008, 32'h0000_00FF);
    wr(12'h004, 32'hFFFF_FFFF);
    rd("R3 masked write", 12'h004, 32'h0000_7F04);

    // R6/R7 alias writes
    wr(12'h884, 32'h1);
    rd("R7 alias write through mask", 12'h004, 32'h0000_7F06);
    wr(12'h8A4, 32'h2);
    rd("R6 alias uses bit 0 only", 12'h004, 32'h0000_7D06);
    wr(12'h8BC, 32'h1);
    wr(12'h844, 32'h0);
    rd("R2/R6 absent pin and other port ignored", 12'h004, 32'h0000_7D06);

    // R11 input latency, R5 alias reads
    @(negedge clk) pad_in = 16'hA5C3;
    rd("R11 level after 1 edge", 12'h010, 32'h0);
    rd("R11 level after 2 edges", 12'h010, 32'h0);
    rd("R11 level after 3 edges", 12'h010, 32'h0000_25C3);
    rd("R5 alias pin0", 12'h880, 32'h1);
    rd("R5 alias pin2", 12'h888, 32'h0);
    rd("R5 alias pin7", 12'h89C, 32'h1);
    rd("R2 alias absent pin15", 12'h8BC, 32'h0);

    // R4 input disable
    wr(12'h00C, 32'h0081_FFFF);
    rd("R4 disable readback", 12'h00C, 32'h0081_0000);
    rd("R4 gated level", 12'h010, 32'h0000_2542);
    rd("R4 alias pin0 gated", 12'h880, 32'h0);
    rd("R5 alias pin1", 12'h884, 32'h1);

    // R10 pull / slew
    wr(12'h014, 32'h4000_0009);
    wr(12'h018, 32'hFFFF_FFFF);
    #1;
    check("R10 pad pull", pad_pull, 32'h0000_0009);
    check("R10 pad slew", {16'h0, pad_slew}, 32'h0000_7FFF);
    rd("R10 pull readback", 12'h014, 32'h0000_0009);
    rd("R10 slew readback", 12'h018, 32'h0000_7FFF);

    // R9 quasi rise through alias
    wr(12'h888, 32'h0);
    #1;
    check("R9 quasi low drives", {31'h0, pad_oe[2]}, 32'h1);
    wr(12'h888, 32'h1);
    #1;
    check("R9 alias rise boost", {30'h0, pad_oe[2], pad_weak_pu[2]}, 32'h2);
    @(negedge clk); #1;
    check("R9 alias rise weak", {30'h0, pad_oe[2], pad_weak_pu[2]}, 32'h1);

    // R8 open-drain low through alias
    wr(12'h884, 32'h0);
    #1;
    check("R8 open-drain low drives", {31'h0, pad_oe[1]}, 32'h1);
    rd("R6 dout after alias writes", 12'h004, 32'h0000_7D04);

    // R12 reset in mid-run
    @(negedge clk); #1;
    arst_n = 1'b0;
    #5;
    check("R12 async reset oe", {16'h0, pad_oe}, 32'h0);
    check("R12 async reset out", {16'h0, pad_out}, 32'h0000_7FFF);
    @(negedge clk);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd("R12 dout after reset", 12'h004, 32'h0000_7FFF);
    rd("R12 pull after reset", 12'h014, 32'h0);
    rd("R12 mask after reset", 12'h008, 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule